// File: doc/BRIEF.md
# Indirect-Access Ethernet Controller Register Unit

This unit is the host-facing register file of a simple Ethernet controller. The host sees a small window of 16-bit ports. It writes a register number into a pointer port and then reaches the selected register through one of two data ports. One data port serves the control/status space and the other serves the bus-configuration space. The window also has a port where a read alone soft-resets the unit, and it exposes the six station-address bytes as three little-endian words.

The unit holds the main control word. That word mixes command bits (INIT, STRT, STOP, TDMD), an interrupt enable, status flags that the host clears by writing ones to them, and a summary error bit. The unit also holds the two halves of the init-block address, a feature mask, a read-only identification pair and the descriptor-style field. Command writes produce one-cycle pulses toward the init loader and the DMA engines. Events from those engines set the status flags, and the status flags drive the interrupt line.

Top module: `nic_reg_unit`

## Requirements
- R1: Byte offsets decide the ports. 0x10 is the control/status data port, 0x12 the pointer port, 0x14 the reset port and 0x16 the configuration data port. Reads at 0x00, 0x02 and 0x04 return station-address bytes {1,0}, {3,2} and {5,4}, with the lower offset in the low byte.
- R2: A read of the pointer port returns the last register number written to it. Only the low 7 bits are kept, and the upper bits read 0.
- R3: A hard reset, or any read of offset 0x14, returns the unit to its reset state in the following cycle. In that state the control word reads 0x0004, the pointer is 0, and the address, feature and style registers are 0. The reset-port read itself returns 0.
- R4: The control word (register 0) uses these bits: INIT=0, STRT=1, STOP=2, TDMD=3, IENA=6, IDON=8, TINT=9, RINT=10, MISS=12, CERR=13, ERR=15. A write with bit 2 set sets STOP, clears STRT and INIT, and emits one stopPulse. STOP wins over INIT or STRT set in the same write.
- R5: IDON, TINT, RINT, MISS and CERR are cleared by writing 1 to their bit. Writing 0 leaves them unchanged. An event arriving in the same cycle as a clear leaves the flag set.
- R6: IENA takes bit 6 of every control-word write. Writing 0x0142 sets STRT, clears STOP and IDON, sets IENA and emits one startPulse. Writing 0x0048 emits one txDemandPulse and keeps IENA set. TDMD always reads 0.
- R7: Register 1 holds init-block address bits [15:0] and register 2 holds bits [31:16]. Both are visible on initAddr. Register 4 is a 16-bit feature mask that reads back as written.
- R8: Register 88 reads 0x1003 and register 89 reads 0x0262. Together they form the 32-bit identity 0x02621003, with tag 3 in bits [11:0] and part code 0x2621 above it. Writes to either register have no effect.
- R9: Configuration register 20 keeps bits [8:0] of a write, and bits [15:9] read 0. The value 0x102 selects 32-bit descriptor style.
- R10: ERR reads as MISS OR CERR and cannot be written. irq equals IENA AND (IDON OR TINT OR RINT OR ERR).
- R11: A control-word write with bit 0 set (and bit 2 clear) sets INIT, clears STOP and emits one initPulse. An initDone input sets IDON.
- R12: Control/status register numbers other than 0, 1, 2, 4, 88 and 89, and configuration register numbers other than 20, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 5 | Byte offset of the host access |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, combinational from hostAddr |
| stationAddr | input | 48 | Station address, byte 0 in bits [7:0] |
| initDone | input | 1 | Init-block load complete, sets IDON |
| txDoneEvt | input | 1 | Transmit complete, sets TINT |
| rxDoneEvt | input | 1 | Receive complete, sets RINT |
| missEvt | input | 1 | Frame missed, sets MISS |
| collEvt | input | 1 | Collision error, sets CERR |
| irq | output | 1 | Interrupt request |
| initPulse | output | 1 | One-cycle request to load the init block |
| startPulse | output | 1 | One-cycle start request to the DMA engines |
| stopPulse | output | 1 | One-cycle halt request to the DMA engines |
| txDemandPulse | output | 1 | One-cycle transmit poll request |
| dmaRun | output | 1 | Level of STRT |
| initAddr | output | 32 | Init-block address from registers 2 and 1 |
| featureMask | output | 16 | Feature mask register |
| descStyle | output | 9 | Descriptor-style field of configuration register 20 |

## Verification
The bench clears one status flag while the others stay set, and it writes zeros to set flags. A design that cleared on write-zero, or cleared every flag on any write, would lose pending interrupts. It drives a receive event in the same cycle as the write that clears RINT. A design where the clear wins would drop that event.

It checks that ERR follows MISS and CERR until both are cleared, and that the identification registers ignore writes. It also checks pointer readback with upper data bits set, and that a reset-port read also clears the pointer and the data registers. A unit that only reset the control word would leave stale pointer or address state behind.

// File: rtl/nic_reg_pkg.sv
`timescale 1ns/1ps
package nic_reg_pkg;
  localparam int DATA_W = 16;
  localparam int OFS_W  = 5;

  localparam logic [OFS_W-1:0] OFS_STA0 = 5'h00;
  localparam logic [OFS_W-1:0] OFS_STA1 = 5'h02;
  localparam logic [OFS_W-1:0] OFS_STA2 = 5'h04;
  localparam logic [OFS_W-1:0] OFS_CSR  = 5'h10;
  localparam logic [OFS_W-1:0] OFS_PTR  = 5'h12;
  localparam logic [OFS_W-1:0] OFS_RST  = 5'h14;
  localparam logic [OFS_W-1:0] OFS_BCR  = 5'h16;

  // control word bit positions
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_IENA = 6;
  localparam int B_ERR  = 15;

  // write-one-to-clear flags: IDON, TINT, RINT, MISS, CERR
  localparam int NFLAG = 5;
  localparam int FLAG_POS [NFLAG] = '{8, 9, 10, 12, 13};
  localparam int F_MISS = 3;
  localparam int F_CERR = 4;

  typedef enum logic [2:0] {
    RD_ZERO, RD_STA0, RD_STA1, RD_STA2, RD_PTR, RD_CSR, RD_BCR
  } rdSelT;

  typedef struct packed {
    logic softRst;
    logic wrPtr;
    logic wrCsr0;
    logic wrCsr1;
    logic wrCsr2;
    logic wrCsr4;
    logic wrBcr20;
  } strobeT;
endpackage

// File: rtl/nic_reg_ctrl.sv
`timescale 1ns/1ps
module nic_reg_ctrl
  import nic_reg_pkg::*;
#(
  parameter int PTR_W = 7
)(
  input  logic [OFS_W-1:0] hostAddr,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [PTR_W-1:0] ptr,
  output strobeT           strobe,
  output rdSelT            rdSel
);
  localparam logic [PTR_W-1:0] N_CSR0  = PTR_W'(0);
  localparam logic [PTR_W-1:0] N_CSR1  = PTR_W'(1);
  localparam logic [PTR_W-1:0] N_CSR2  = PTR_W'(2);
  localparam logic [PTR_W-1:0] N_CSR4  = PTR_W'(4);
  localparam logic [PTR_W-1:0] N_BCR20 = PTR_W'(20);

  logic rstHit, csrWr, bcrWr;

  assign rstHit = hostRd && (hostAddr == OFS_RST);
  assign csrWr  = hostWr && !rstHit && (hostAddr == OFS_CSR);
  assign bcrWr  = hostWr && !rstHit && (hostAddr == OFS_BCR);

  always_comb begin
    strobe         = '0;
    strobe.softRst = rstHit;
    strobe.wrPtr   = hostWr && !rstHit && (hostAddr == OFS_PTR);
    strobe.wrCsr0  = csrWr && (ptr == N_CSR0);
    strobe.wrCsr1  = csrWr && (ptr == N_CSR1);
    strobe.wrCsr2  = csrWr && (ptr == N_CSR2);
    strobe.wrCsr4  = csrWr && (ptr == N_CSR4);
    strobe.wrBcr20 = bcrWr && (ptr == N_BCR20);
  end

  always_comb begin
    unique case (hostAddr)
      OFS_STA0: rdSel = RD_STA0;
      OFS_STA1: rdSel = RD_STA1;
      OFS_STA2: rdSel = RD_STA2;
      OFS_PTR:  rdSel = RD_PTR;
      OFS_CSR:  rdSel = RD_CSR;
      OFS_BCR:  rdSel = RD_BCR;
      default:  rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/nic_reg_dp.sv
`timescale 1ns/1ps
module nic_reg_dp
  import nic_reg_pkg::*;
#(
  parameter int          PTR_W     = 7,
  parameter int          STYLE_W   = 9,
  parameter logic [15:0] PART_CODE = 16'h2621,
  parameter logic [11:0] ID_TAG    = 12'h003
)(
  input  logic              clk,
  input  logic              rst_n,
  input  strobeT            strobe,
  input  rdSelT             rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [47:0]       stationAddr,
  input  logic [NFLAG-1:0]  statusEvt,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              initPulse,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              txDemandPulse,
  output logic              dmaRun,
  output logic [31:0]       initAddr,
  output logic [DATA_W-1:0] featureMask,
  output logic [STYLE_W-1:0] descStyle,
  output logic [DATA_W-1:0] csr0Word
);
  localparam logic [31:0]       ID_WORD = {4'h0, PART_CODE, ID_TAG};
  localparam logic [PTR_W-1:0]  N_ID_LO = PTR_W'(88);
  localparam logic [PTR_W-1:0]  N_ID_HI = PTR_W'(89);
  localparam logic [PTR_W-1:0]  N_BCR20 = PTR_W'(20);

  logic initBit, strtBit, stopBit, ienaBit;
  logic [NFLAG-1:0] flags;
  logic [DATA_W-1:0] addrLo, addrHi;
  logic errBit;
  logic stopReq;

  assign stopReq = wdata[B_STOP];

  // pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ptr <= '0;
    else if (strobe.softRst) ptr <= '0;
    else if (strobe.wrPtr)  ptr <= wdata[PTR_W-1:0];
  end

  // command bits and pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initBit <= 1'b0; strtBit <= 1'b0; stopBit <= 1'b1; ienaBit <= 1'b0;
      initPulse <= 1'b0; startPulse <= 1'b0; stopPulse <= 1'b0; txDemandPulse <= 1'b0;
    end else if (strobe.softRst) begin
      initBit <= 1'b0; strtBit <= 1'b0; stopBit <= 1'b1; ienaBit <= 1'b0;
      initPulse <= 1'b0; startPulse <= 1'b0; stopPulse <= 1'b0; txDemandPulse <= 1'b0;
    end else begin
      initPulse     <= strobe.wrCsr0 && wdata[B_INIT] && !stopReq;
      startPulse    <= strobe.wrCsr0 && wdata[B_STRT] && !stopReq;
      stopPulse     <= strobe.wrCsr0 && stopReq;
      txDemandPulse <= strobe.wrCsr0 && wdata[B_TDMD] && !stopReq;
      if (strobe.wrCsr0) begin
        ienaBit <= wdata[B_IENA];
        if (stopReq) begin
          stopBit <= 1'b1;
          strtBit <= 1'b0;
          initBit <= 1'b0;
        end else begin
          if (wdata[B_INIT]) begin initBit <= 1'b1; stopBit <= 1'b0; end
          if (wdata[B_STRT]) begin strtBit <= 1'b1; stopBit <= 1'b0; end
        end
      end
    end
  end

  // write-one-to-clear status flags, event wins over clear
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    flags[i] <= 1'b0;
      else if (strobe.softRst)                       flags[i] <= 1'b0;
      else if (statusEvt[i])                         flags[i] <= 1'b1;
      else if (strobe.wrCsr0 && wdata[FLAG_POS[i]])  flags[i] <= 1'b0;
    end
  end

  // data registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrLo <= '0; addrHi <= '0; featureMask <= '0; descStyle <= '0;
    end else if (strobe.softRst) begin
      addrLo <= '0; addrHi <= '0; featureMask <= '0; descStyle <= '0;
    end else begin
      if (strobe.wrCsr1)  addrLo      <= wdata;
      if (strobe.wrCsr2)  addrHi      <= wdata;
      if (strobe.wrCsr4)  featureMask <= wdata;
      if (strobe.wrBcr20) descStyle   <= wdata[STYLE_W-1:0];
    end
  end

  assign errBit = flags[F_MISS] | flags[F_CERR];

  always_comb begin
    csr0Word          = '0;
    csr0Word[B_INIT]  = initBit;
    csr0Word[B_STRT]  = strtBit;
    csr0Word[B_STOP]  = stopBit;
    csr0Word[B_IENA]  = ienaBit;
    csr0Word[B_ERR]   = errBit;
    for (int i = 0; i < NFLAG; i++) csr0Word[FLAG_POS[i]] = flags[i];
  end

  assign irq      = ienaBit & ((|flags[2:0]) | errBit);
  assign dmaRun   = strtBit;
  assign initAddr = {addrHi, addrLo};

  // read mux
  logic [DATA_W-1:0] csrRead, bcrRead;

  always_comb begin
    unique case (ptr)
      PTR_W'(0): csrRead = csr0Word;
      PTR_W'(1): csrRead = addrLo;
      PTR_W'(2): csrRead = addrHi;
      PTR_W'(4): csrRead = featureMask;
      N_ID_LO:   csrRead = ID_WORD[15:0];
      N_ID_HI:   csrRead = ID_WORD[31:16];
      default:   csrRead = '0;
    endcase
  end

  assign bcrRead = (ptr == N_BCR20) ? DATA_W'(descStyle) : '0;

  always_comb begin
    unique case (rdSel)
      RD_STA0: rdata = stationAddr[15:0];
      RD_STA1: rdata = stationAddr[31:16];
      RD_STA2: rdata = stationAddr[47:32];
      RD_PTR:  rdata = DATA_W'(ptr);
      RD_CSR:  rdata = csrRead;
      RD_BCR:  rdata = bcrRead;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/nic_reg_unit.sv
`timescale 1ns/1ps
module nic_reg_unit
  import nic_reg_pkg::*;
#(
  parameter int          PTR_W     = 7,
  parameter int          STYLE_W   = 9,
  parameter logic [15:0] PART_CODE = 16'h2621,
  parameter logic [11:0] ID_TAG    = 12'h003
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   hostAddr,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic [15:0]  hostWdata,
  output logic [15:0]  hostRdata,
  input  logic [47:0]  stationAddr,
  input  logic         initDone,
  input  logic         txDoneEvt,
  input  logic         rxDoneEvt,
  input  logic         missEvt,
  input  logic         collEvt,
  output logic         irq,
  output logic         initPulse,
  output logic         startPulse,
  output logic         stopPulse,
  output logic         txDemandPulse,
  output logic         dmaRun,
  output logic [31:0]  initAddr,
  output logic [15:0]  featureMask,
  output logic [8:0]   descStyle
);
  strobeT           strobe;
  rdSelT            rdSel;
  logic [PTR_W-1:0] ptr;
  logic [15:0]      csr0Word;
  logic [NFLAG-1:0] statusEvt;

  assign statusEvt = {collEvt, missEvt, rxDoneEvt, txDoneEvt, initDone};

  nic_reg_ctrl #(.PTR_W(PTR_W)) i_ctrl (
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .ptr(ptr), .strobe(strobe), .rdSel(rdSel)
  );

  nic_reg_dp #(
    .PTR_W(PTR_W), .STYLE_W(STYLE_W), .PART_CODE(PART_CODE), .ID_TAG(ID_TAG)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdSel(rdSel),
    .wdata(hostWdata), .stationAddr(stationAddr), .statusEvt(statusEvt),
    .ptr(ptr), .rdata(hostRdata), .irq(irq),
    .initPulse(initPulse), .startPulse(startPulse), .stopPulse(stopPulse),
    .txDemandPulse(txDemandPulse), .dmaRun(dmaRun), .initAddr(initAddr),
    .featureMask(featureMask), .descStyle(descStyle), .csr0Word(csr0Word)
  );
endmodule

// File: rtl/nic_reg_checker.sv
`timescale 1ns/1ps
module nic_reg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  hostAddr,
  input logic        hostWr,
  input logic        hostRd,
  input logic [15:0] hostWdata,
  input logic        initDone,
  input logic        txDoneEvt,
  input logic        irq,
  input logic        initPulse,
  input logic        startPulse,
  input logic        stopPulse,
  input logic        dmaRun,
  input logic [6:0]  ptr,
  input logic [15:0] csr0Word
);
  logic rstRead, ctlWrite;
  assign rstRead  = hostRd && hostAddr == 5'h14;
  assign ctlWrite = hostWr && hostAddr == 5'h10 && ptr == 7'd0 && !rstRead;

  assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rstRead |=> (csr0Word == 16'h0004 && ptr == 7'd0));

  assert_ptr_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWr && hostAddr == 5'h12 && !rstRead) |=> ptr == $past(hostWdata[6:0]));

  assert_stop_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrite && hostWdata[2]) |=> (stopPulse && !dmaRun && csr0Word[2]));

  assert_w1c_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrite && !hostWdata[9] && !txDoneEvt) |=> csr0Word[9] == $past(csr0Word[9]));

  assert_idon_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (initDone && !rstRead) |=> csr0Word[8]);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr0Word[6]);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);

  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stopPulse, startPulse}) && $onehot0({stopPulse, initPulse}));
endmodule

bind nic_reg_unit nic_reg_checker i_checker (
  .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWr(hostWr),
  .hostRd(hostRd), .hostWdata(hostWdata), .initDone(initDone),
  .txDoneEvt(txDoneEvt), .irq(irq), .initPulse(initPulse),
  .startPulse(startPulse), .stopPulse(stopPulse), .dmaRun(dmaRun),
  .ptr(ptr), .csr0Word(csr0Word)
);

// File: tb/test_nic_reg_unit.sv
`timescale 1ns/1ps
module test_nic_reg_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic [47:0] stationAddr = 48'h6655_4433_2211;
  logic initDone = 0, txDoneEvt = 0, rxDoneEvt = 0, missEvt = 0, collEvt = 0;
  logic irq, initPulse, startPulse, stopPulse, txDemandPulse, dmaRun;
  logic [31:0] initAddr;
  logic [15:0] featureMask;
  logic [8:0]  descStyle;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nic_reg_unit i_nic_reg_unit (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .stationAddr(stationAddr), .initDone(initDone), .txDoneEvt(txDoneEvt),
    .rxDoneEvt(rxDoneEvt), .missEvt(missEvt), .collEvt(collEvt), .irq(irq),
    .initPulse(initPulse), .startPulse(startPulse), .stopPulse(stopPulse),
    .txDemandPulse(txDemandPulse), .dmaRun(dmaRun), .initAddr(initAddr),
    .featureMask(featureMask), .descStyle(descStyle)
  );

  // {op(1: read/check), req(4), addr(5), data(16), expect(16)}
  localparam int NV = 32;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 4'd0,  5'h12, 16'h0004, 16'h0000},
    {1'b0, 4'd0,  5'h10, 16'hABCD, 16'h0000},
    {1'b1, 4'd7,  5'h10, 16'h0000, 16'hABCD}, // R7 feature mask
    {1'b0, 4'd0,  5'h12, 16'h0001, 16'h0000},
    {1'b0, 4'd0,  5'h10, 16'h1234, 16'h0000},
    {1'b1, 4'd7,  5'h10, 16'h0000, 16'h1234}, // R7 low half
    {1'b0, 4'd0,  5'h12, 16'h0002, 16'h0000},
    {1'b0, 4'd0,  5'h10, 16'h00FE, 16'h0000},
    {1'b1, 4'd7,  5'h10, 16'h0000, 16'h00FE}, // R7 high half
    {1'b1, 4'd2,  5'h12, 16'h0000, 16'h0002}, // R2 readback
    {1'b0, 4'd0,  5'h12, 16'h0058, 16'h0000},
    {1'b1, 4'd2,  5'h12, 16'h0000, 16'h0058}, // R2 extended number
    {1'b1, 4'd8,  5'h10, 16'h0000, 16'h1003}, // R8 id low
    {1'b0, 4'd0,  5'h12, 16'h0059, 16'h0000},
    {1'b1, 4'd8,  5'h10, 16'h0000, 16'h0262}, // R8 id high
    {1'b0, 4'd0,  5'h10, 16'hFFFF, 16'h0000},
    {1'b1, 4'd8,  5'h10, 16'h0000, 16'h0262}, // R8 write ignored
    {1'b0, 4'd0,  5'h12, 16'h0014, 16'h0000},
    {1'b0, 4'd0,  5'h16, 16'h0102, 16'h0000},
    {1'b1, 4'd9,  5'h16, 16'h0000, 16'h0102}, // R9 style
    {1'b0, 4'd0,  5'h16, 16'hFFFF, 16'h0000},
    {1'b1, 4'd9,  5'h16, 16'h0000, 16'h01FF}, // R9 width
    {1'b0, 4'd0,  5'h12, 16'hFFFF, 16'h0000},
    {1'b1, 4'd2,  5'h12, 16'h0000, 16'h007F}, // R2 upper bits
    {1'b0, 4'd0,  5'h12, 16'h0005, 16'h0000},
    {1'b0, 4'd0,  5'h10, 16'h5555, 16'h0000},
    {1'b1, 4'd12, 5'h10, 16'h0000, 16'h0000}, // R12 unimplemented
    {1'b1, 4'd1,  5'h00, 16'h0000, 16'h2211}, // R1 station word 0
    {1'b1, 4'd1,  5'h02, 16'h0000, 16'h4433}, // R1 station word 1
    {1'b1, 4'd1,  5'h04, 16'h0000, 16'h6655}, // R1 station word 2
    {1'b0, 4'd0,  5'h12, 16'h0000, 16'h0000},
    {1'b1, 4'd4,  5'h10, 16'h0000, 16'h0004}  // R4 control word
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1; hostRd = 1'b0;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1; hostWr = 1'b0;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic readCsr0(input string req, input logic [15:0] exp);
    logic [15:0] v;
    hostRead(5'h10, v);
    check(req, 32'(v), 32'(exp));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    readCsr0("R3", 16'h0004);
    check("R3 irq", 32'(irq), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) begin
        hostRead(VEC[i][36:32], v);
        nChecks++;
        if (v !== VEC[i][15:0]) begin
          nFails++;
          $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                   VEC[i][40:37], i, v, VEC[i][15:0]);
        end
      end else begin
        hostWrite(VEC[i][36:32], VEC[i][31:16]);
      end
    end
    check("R7 initAddr", initAddr, 32'h00FE_1234);
    check("R9 descStyle", 32'(descStyle), 32'h1FF);

    // R11 init pulse and done
    hostWrite(5'h10, 16'h0001);
    #1 check("R11 initPulse", 32'(initPulse), 32'd1);
    readCsr0("R11 init set", 16'h0001);
    @(negedge clk); initDone = 1'b1; @(negedge clk); initDone = 1'b0;
    readCsr0("R11 idon", 16'h0101);
    check("R10 irq gated", 32'(irq), 32'd0);

    // R6 start + clear IDON + IENA
    hostWrite(5'h10, 16'h0142);
    #1 check("R6 startPulse", 32'(startPulse), 32'd1);
    readCsr0("R6 0x0142", 16'h0043);
    check("R6 dmaRun", 32'(dmaRun), 32'd1);

    // R5/R10 TINT
    @(negedge clk); txDoneEvt = 1'b1; @(negedge clk); txDoneEvt = 1'b0;
    readCsr0("R5 tint set", 16'h0243);
    check("R10 irq tint", 32'(irq), 32'd1);
    hostWrite(5'h10, 16'h0040);
    readCsr0("R5 write zero", 16'h0243);
    hostWrite(5'h10, 16'h0240);
    readCsr0("R5 w1c", 16'h0043);
    check("R10 irq clear", 32'(irq), 32'd0);

    // R6 transmit demand
    hostWrite(5'h10, 16'h0048);
    #1 check("R6 txDemandPulse", 32'(txDemandPulse), 32'd1);
    readCsr0("R6 0x0048", 16'h0043);

    // R10 ERR summary
    @(negedge clk); missEvt = 1'b1; @(negedge clk); missEvt = 1'b0;
    readCsr0("R10 miss err", 16'h9043);
    check("R10 irq err", 32'(irq), 32'd1);
    @(negedge clk); collEvt = 1'b1; @(negedge clk); collEvt = 1'b0;
    readCsr0("R10 cerr", 16'hB043);
    hostWrite(5'h10, 16'h1040);
    readCsr0("R10 err holds", 16'hA043);
    hostWrite(5'h10, 16'h2040);
    readCsr0("R10 err clear", 16'h0043);

    // R5 event wins over clear
    @(negedge clk);
    hostAddr = 5'h10; hostWdata = 16'h0440; hostWr = 1'b1; rxDoneEvt = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; rxDoneEvt = 1'b0;
    readCsr0("R5 set wins", 16'h0443);
    hostWrite(5'h10, 16'h0440);
    readCsr0("R5 rint clear", 16'h0043);

    // R4 STOP dominates
    hostWrite(5'h10, 16'h0007);
    #1 check("R4 stopPulse", 32'(stopPulse), 32'd1);
    check("R4 no start", 32'(startPulse), 32'd0);
    readCsr0("R4 stop", 16'h0004);
    check("R4 dmaRun", 32'(dmaRun), 32'd0);

    // R3 reset port
    hostWrite(5'h12, 16'h0004);
    hostWrite(5'h10, 16'h00AA);
    hostWrite(5'h10 - 5'h10 + 5'h12, 16'h0000);
    hostWrite(5'h10, 16'h0041);
    hostWrite(5'h12, 16'h0004);
    hostRead(5'h14, v);
    check("R3 reset read data", 32'(v), 32'd0);
    hostRead(5'h12, v);
    check("R3 ptr cleared", 32'(v), 32'd0);
    readCsr0("R3 csr0 after reset", 16'h0004);
    check("R3 feature cleared", 32'(featureMask), 32'd0);
    check("R3 addr cleared", initAddr, 32'd0);

    finish_run();
  end
endmodule